// File: doc/BRIEF.md
# Converter Startup Sequencer

This block walks an offline converter controller from the moment its supply is good to steady regulation. It holds the startup bias path on until a fixed time after turn-on and runs a first phase that begins with a short protected interval: a low current limit and a fixed switching frequency. A soft-start ceiling on duty opens during that phase. A proportional-gain settling phase follows. The sequencer then waits for a line-peak event and hands the loop over to integral gain a fixed delay after that event.

All timing counts an external 1 ms enable pulse, `tick_ms`. The one exception is the delay after the line peak, which counts an external 0.5 ms pulse, `tick_half`. The states are IDLE (code 0), CCM_PREVENT (1), SOFT_START (2), P_GAIN (3), WAIT_PEAK (4) and I_GAIN (5).

The named transitions are:
- power-up: IDLE to CCM_PREVENT.
- guard-done: CCM_PREVENT to SOFT_START.
- comp-settled, or soft-timeout: SOFT_START to P_GAIN.
- settle-done: P_GAIN to WAIT_PEAK.
- peak-aligned: WAIT_PEAK to I_GAIN.
- lockout: any state to IDLE.

Top module: `ssq_startup_seq`

## Requirements
- R1: An asynchronous reset, or the synchronous `uvlo` input, puts the block in IDLE. `uvlo` acts at the next clock edge from any state and overrides every other input. In IDLE: `phase`=0, `bias_en`=1, `ilim_low`=0, `freq_fix`=0, `duty_ceil`=0 and `gain_int`=0.
- R2: The `phase` output carries the state code: IDLE 0, CCM_PREVENT 1, SOFT_START 2, P_GAIN 3, WAIT_PEAK 4, I_GAIN 5. In IDLE, `supply_ok` high moves the block to CCM_PREVENT at the next edge.
- R3: `bias_en` stays 1 until 500 `tick_ms` pulses have been seen outside IDLE, counted from the edge that leaves IDLE. It then stays 0 until the next lockout.
- R4: `ilim_low` and `freq_fix` are 1 only in CCM_PREVENT. CCM_PREVENT lasts exactly 2 `tick_ms` pulses, and `comp_low` has no effect in it.
- R5: `duty_ceil` (8 bits) is 0 in IDLE. In CCM_PREVENT and SOFT_START it equals floor(255*n/26), where n counts ticks since the block entered CCM_PREVENT, and it holds 255 once n reaches 26. It is 255 in P_GAIN, WAIT_PEAK and I_GAIN.
- R6: In SOFT_START, `comp_low` high moves the block to P_GAIN at the next edge.
- R7: If `comp_low` never rises, the 100th tick counted from CCM_PREVENT entry moves the block from SOFT_START to P_GAIN.
- R8: P_GAIN lasts exactly 45 ticks, with `gain_int`=0, and then moves to WAIT_PEAK.
- R9: In WAIT_PEAK, `tick_half` pulses are ignored until a `peak_pulse` arrives. The third `tick_half` after that peak moves the block to I_GAIN. Further peaks during the count are ignored.
- R10: In I_GAIN `gain_int`=1, and the block stays there until a lockout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| uvlo | input | 1 | Undervoltage lockout, returns to IDLE |
| tick_ms | input | 1 | One-cycle 1 ms enable pulse |
| tick_half | input | 1 | One-cycle 0.5 ms enable pulse |
| supply_ok | input | 1 | Supply above the turn-on level |
| comp_low | input | 1 | Compensation voltage has fallen below its threshold |
| peak_pulse | input | 1 | Line-peak detection pulse |
| bias_en | output | 1 | High-voltage startup bias enable |
| ilim_low | output | 1 | Selects the reduced current limit |
| freq_fix | output | 1 | Forces the fixed switching frequency |
| duty_ceil | output | 8 | Duty ceiling ramp |
| gain_int | output | 1 | 1 selects integral gain, 0 proportional |
| phase | output | 3 | Current state code |

## Verification
A wrong state code appears on `phase` one clock after the faulty edge. A timer that is off by one shows as a transition one tick early or late, so the bench reads `phase` after every tick. A miscounted phase-one timer also shows at once in `duty_ceil`, which the bench compares after every tick of the ramp. A bias timer fault stays hidden until the 499th or 500th tick, so the bench samples `bias_en` at exactly those two points. A wrong arming rule in WAIT_PEAK shows as an early or late I_GAIN relative to stray peaks and half ticks.

// File: rtl/ssq_pkg.sv
package ssq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_CCM   = 3'd1,
        ST_SOFT  = 3'd2,
        ST_PROP  = 3'd3,
        ST_WAIT  = 3'd4,
        ST_INTEG = 3'd5
    } ssq_state_e;
endpackage

// File: rtl/ssq_tick_counter.sv
module ssq_tick_counter #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (clr)
            cnt <= '0;
        else if (inc)
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/ssq_bias_timer.sv
module ssq_bias_timer #(
    parameter int BIAS_TICKS = 500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic uvlo,
    input  logic running,
    input  logic tick_ms,
    output logic bias_en
);
    localparam int BW = $clog2(BIAS_TICKS + 1);
    localparam logic [BW-1:0] LIMIT = BW'(BIAS_TICKS);

    logic [BW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (uvlo || !running)
            cnt_q <= '0;
        else if (tick_ms && (cnt_q < LIMIT))
            cnt_q <= cnt_q + 1'b1;
    end

    assign bias_en = (cnt_q < LIMIT);

    // R3
    bias_stays_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bias_en && !uvlo && running) |=> !bias_en);
endmodule

// File: rtl/ssq_duty_ramp.sv
module ssq_duty_ramp #(
    parameter int TW         = 7,
    parameter int DUTY_W     = 8,
    parameter int RAMP_TICKS = 26
) (
    input  logic              ramp_active,
    input  logic              ramp_done,
    input  logic [TW-1:0]     n,
    output logic [DUTY_W-1:0] duty
);
    localparam int PW = TW + DUTY_W;
    localparam logic [PW-1:0] FULL   = PW'((1 << DUTY_W) - 1);
    localparam logic [PW-1:0] STEPS  = PW'(RAMP_TICKS);

    logic [PW-1:0] prod;
    logic [PW-1:0] quot;

    always_comb begin
        prod = PW'(n) * FULL;
        quot = prod / STEPS;
        if (ramp_done)
            duty = FULL[DUTY_W-1:0];
        else if (!ramp_active)
            duty = '0;
        else if (PW'(n) >= STEPS)
            duty = FULL[DUTY_W-1:0];
        else
            duty = quot[DUTY_W-1:0];
    end
endmodule

// File: rtl/ssq_startup_seq.sv
module ssq_startup_seq
    import ssq_pkg::*;
#(
    parameter int BIAS_TICKS   = 500,
    parameter int CCM_TICKS    = 2,
    parameter int RAMP_TICKS   = 26,
    parameter int P1_MAX_TICKS = 100,
    parameter int SETTLE_TICKS = 45,
    parameter int PEAK_HALVES  = 3,
    parameter int DUTY_W       = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              uvlo,
    input  logic              tick_ms,
    input  logic              tick_half,
    input  logic              supply_ok,
    input  logic              comp_low,
    input  logic              peak_pulse,
    output logic              bias_en,
    output logic              ilim_low,
    output logic              freq_fix,
    output logic [DUTY_W-1:0] duty_ceil,
    output logic              gain_int,
    output logic [2:0]        phase
);
    localparam int TMAX = (P1_MAX_TICKS > SETTLE_TICKS) ? P1_MAX_TICKS : SETTLE_TICKS;
    localparam int TW   = $clog2(TMAX + 1);
    localparam int HW   = $clog2(PEAK_HALVES + 1);
    localparam logic [TW-1:0] CCM_LAST    = TW'(CCM_TICKS - 1);
    localparam logic [TW-1:0] P1_LAST     = TW'(P1_MAX_TICKS - 1);
    localparam logic [TW-1:0] SETTLE_LAST = TW'(SETTLE_TICKS - 1);
    localparam logic [HW-1:0] HALF_LAST   = HW'(PEAK_HALVES - 1);

    ssq_state_e    state_q, state_d;
    logic [TW-1:0] tmr;
    logic [HW-1:0] hcnt;
    logic          armed_q;
    logic          tmr_clr, tmr_inc, h_clr, h_inc;
    logic          ramp_active, ramp_done;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // peak arming flag for WAIT_PEAK
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            armed_q <= 1'b0;
        else if (state_q != ST_WAIT || uvlo)
            armed_q <= 1'b0;
        else if (peak_pulse)
            armed_q <= 1'b1;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (supply_ok) state_d = ST_CCM;
            ST_CCM:   if (tick_ms && tmr == CCM_LAST) state_d = ST_SOFT;
            ST_SOFT:  if (comp_low || (tick_ms && tmr == P1_LAST)) state_d = ST_PROP;
            ST_PROP:  if (tick_ms && tmr == SETTLE_LAST) state_d = ST_WAIT;
            ST_WAIT:  if (armed_q && tick_half && hcnt == HALF_LAST) state_d = ST_INTEG;
            ST_INTEG: state_d = ST_INTEG;
            default:  state_d = ST_IDLE;
        endcase
        if (uvlo)
            state_d = ST_IDLE;
    end

    // phase timer: runs continuously across CCM_PREVENT and SOFT_START
    assign tmr_clr = uvlo || (state_q == ST_IDLE) ||
                     ((state_d != state_q) && !(state_q == ST_CCM && state_d == ST_SOFT));
    assign tmr_inc = tick_ms && (state_q == ST_CCM || state_q == ST_SOFT || state_q == ST_PROP);

    ssq_tick_counter #(.W(TW)) u_phase_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tmr_clr),
        .inc   (tmr_inc),
        .cnt   (tmr)
    );

    // half-tick counter after the arming peak
    assign h_clr = (state_q != ST_WAIT) || (peak_pulse && !armed_q);
    assign h_inc = tick_half && armed_q;

    ssq_tick_counter #(.W(HW)) u_half_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (h_clr),
        .inc   (h_inc),
        .cnt   (hcnt)
    );

    ssq_bias_timer #(.BIAS_TICKS(BIAS_TICKS)) u_bias (
        .clk     (clk),
        .rst_n   (rst_n),
        .uvlo    (uvlo),
        .running (state_q != ST_IDLE),
        .tick_ms (tick_ms),
        .bias_en (bias_en)
    );

    ssq_duty_ramp #(.TW(TW), .DUTY_W(DUTY_W), .RAMP_TICKS(RAMP_TICKS)) u_ramp (
        .ramp_active (ramp_active),
        .ramp_done   (ramp_done),
        .n           (tmr),
        .duty        (duty_ceil)
    );

    // output decode
    always_comb begin
        ilim_low    = 1'b0;
        freq_fix    = 1'b0;
        gain_int    = 1'b0;
        ramp_active = 1'b0;
        ramp_done   = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_CCM:   begin ilim_low = 1'b1; freq_fix = 1'b1; ramp_active = 1'b1; end
            ST_SOFT:  ramp_active = 1'b1;
            ST_PROP:  ramp_done = 1'b1;
            ST_WAIT:  ramp_done = 1'b1;
            ST_INTEG: begin ramp_done = 1'b1; gain_int = 1'b1; end
            default:  ;
        endcase
    end

    assign phase = state_q;

    // R1
    uvlo_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        uvlo |=> (phase == 3'd0));

    // R2
    idle_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CCM && $past(state_q) == ST_IDLE) |-> $past(supply_ok));

    // R4
    ccm_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SOFT && $past(state_q) == ST_CCM) |-> ($past(tick_ms) && $past(tmr) == CCM_LAST));

    // R7
    soft_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PROP && $past(state_q) == ST_SOFT) |-> ($past(comp_low) || $past(tmr) == P1_LAST));

    // R5
    duty_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_CCM || state_q == ST_SOFT) && ($past(state_q) == ST_CCM || $past(state_q) == ST_SOFT))
        |-> (duty_ceil >= $past(duty_ceil)));

    // R9
    integ_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_INTEG && $past(state_q) == ST_WAIT) |-> ($past(armed_q) && $past(tick_half)));

    // R10
    integ_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gain_int && !uvlo) |=> gain_int);
endmodule

// File: tb/ssq_startup_seq_bench.sv
module ssq_startup_seq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       uvlo = 1'b0, tick_ms = 1'b0, tick_half = 1'b0;
    logic       supply_ok = 1'b0, comp_low = 1'b0, peak_pulse = 1'b0;
    logic       bias_en, ilim_low, freq_fix, gain_int;
    logic [7:0] duty_ceil;
    logic [2:0] phase;

    int checks = 0;
    int errors = 0;
    int tot = 0;
    int cyc = 0;

    ssq_startup_seq u_ssq_startup_seq (
        .clk(clk), .rst_n(rst_n), .uvlo(uvlo), .tick_ms(tick_ms), .tick_half(tick_half),
        .supply_ok(supply_ok), .comp_low(comp_low), .peak_pulse(peak_pulse),
        .bias_en(bias_en), .ilim_low(ilim_low), .freq_fix(freq_fix),
        .duty_ceil(duty_ceil), .gain_int(gain_int), .phase(phase)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > WATCHDOG) begin
            errors = errors + 1;
            $display("FAIL watchdog: run hung, actual %0d cycles expected < %0d", cyc, WATCHDOG);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    function automatic int exp_duty(int n);
        if (n >= 26) return 255;
        return (n * 255) / 26;
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_tick();
        @(negedge clk) tick_ms = 1'b1;
        @(negedge clk) tick_ms = 1'b0;
        tot++;
        repeat ($urandom_range(0, 3)) @(negedge clk);
    endtask

    task automatic do_half();
        @(negedge clk) tick_half = 1'b1;
        @(negedge clk) tick_half = 1'b0;
    endtask

    task automatic do_peak();
        @(negedge clk) peak_pulse = 1'b1;
        @(negedge clk) peak_pulse = 1'b0;
    endtask

    task automatic do_uvlo();
        @(negedge clk) begin uvlo = 1'b1; tick_ms = 1'b1; peak_pulse = 1'b1; end
        @(negedge clk) begin uvlo = 1'b0; tick_ms = 1'b0; peak_pulse = 1'b0; end
    endtask

    task automatic check_idle(string tag);
        chk({tag, " R1 phase"}, phase, 0);
        chk({tag, " R1 bias"}, bias_en, 1);
        chk({tag, " R1 duty"}, duty_ceil, 0);
        chk({tag, " R1 ilim"}, ilim_low, 0);
        chk({tag, " R1 gain"}, gain_int, 0);
    endtask

    task automatic start_run();
        @(negedge clk) supply_ok = 1'b1;
        @(negedge clk) supply_ok = 1'b0;
        tot = 0;
        chk("R2 enter CCM_PREVENT", phase, 1);
        chk("R4 ilim_low in CCM", ilim_low, 1);
        chk("R4 freq_fix in CCM", freq_fix, 1);
        chk("R5 duty at n=0", duty_ceil, 0);
    endtask

    task automatic run_comp_path(int k, bit full_bias);
        start_run();
        comp_low = 1'b1;
        do_tick();
        comp_low = 1'b0;
        chk("R4 comp_low ignored in CCM", phase, 1);
        chk("R5 duty n=1", duty_ceil, exp_duty(1));
        do_tick();
        chk("R4 CCM ends after 2 ticks", phase, 2);
        chk("R4 ilim_low off in SOFT", ilim_low, 0);
        chk("R5 duty n=2", duty_ceil, exp_duty(2));
        for (int i = 0; i < k; i++) begin
            do_tick();
            chk("R5 ramp", duty_ceil, exp_duty(tot));
            chk("R6 still SOFT", phase, 2);
        end
        @(negedge clk) comp_low = 1'b1;
        @(negedge clk) comp_low = 1'b0;
        chk("R6 comp_low ends SOFT", phase, 3);
        chk("R5 duty open in P_GAIN", duty_ceil, 255);
        for (int i = 1; i <= 45; i++) begin
            do_tick();
            chk("R8 P_GAIN length", phase, (i < 45) ? 3 : 4);
        end
        chk("R8 gain prop", gain_int, 0);
        repeat (4) do_half();
        chk("R9 half ticks before peak ignored", phase, 4);
        do_peak();
        do_half();
        do_half();
        chk("R9 two halves after peak", phase, 4);
        do_peak();
        do_half();
        chk("R9 third half enters I_GAIN", phase, 5);
        chk("R10 gain_int", gain_int, 1);
        if (full_bias) begin
            while (tot < 499) do_tick();
            chk("R3 bias on at 499", bias_en, 1);
            do_tick();
            chk("R3 bias off at 500", bias_en, 0);
            repeat (3) do_tick();
            chk("R3 bias stays off", bias_en, 0);
            chk("R10 I_GAIN holds", phase, 5);
        end
        do_uvlo();
        check_idle("lockout");
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        check_idle("reset");
        @(negedge clk) rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check_idle("after reset");

        run_comp_path(5, 1'b1);

        // timeout path: comp_low never rises
        start_run();
        for (int i = 1; i <= 100; i++) begin
            do_tick();
            chk("R7 phase during phase one", phase, (tot < 2) ? 1 : ((tot < 100) ? 2 : 3));
            chk("R5 ramp in timeout run", duty_ceil, (tot < 100) ? exp_duty(tot) : 255);
        end
        repeat (7) do_tick();
        chk("R8 still P_GAIN", phase, 3);
        do_uvlo();
        check_idle("uvlo in P_GAIN");
        repeat (5) @(negedge clk);
        chk("R1 idle waits for supply", phase, 0);

        for (int r = 0; r < 4; r++)
            run_comp_path(int'($urandom_range(0, 30)), 1'b0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule